// File: doc/BRIEF.md
# Status-Coded I2C Master Byte Engine

This block is a byte-level master for an I2C / SMBus two-wire bus. A controlling sequencer drives three level controls (begin, halt, acknowledge-enable), loads a data register, and clears an event flag. The engine makes the bus conditions and clocks one byte at a time. After each bus event it raises the flag, shows an eight-bit status code, and holds SCL low until the flag is cleared. A halt request makes a STOP. A begin request makes a START, or a repeated START if the bus is already held. Both together make a STOP followed by a new START.

The same data register serves both directions. After a START it carries the slave address; bit 0 chooses read (1) or write (0). In a write it carries the outgoing data bytes, and in a read it receives the incoming bytes. The SCL rate comes from a divider input `clk_div`: one bus bit takes four quarter-periods of `clk_div+1` clock cycles each. For 100 kHz SCL, set `clk_div` to f_clk/400 kHz − 1. Both pins are open-drain: the `*_oe` outputs pull the line low when high.

Engine states and transitions: IDLE goes to START when begin is high. START goes to HOLD (status 0x08 or 0x10). HOLD, on a flag clear, goes to STOP when halt is high, to START when only begin is high, and otherwise to BIT. BIT goes to ACK after the last bit. ACK goes to HOLD with the byte status. STOP goes to IDLE (status 0xF8), or to START when begin was also requested. Any unlisted state falls to STOP.

Top module: `sbe_master`

## Requirements
- R1: After reset, status is 0xF8, the flag is low and neither SCL nor SDA is pulled low.
- R2: With the bus idle, a high begin control makes SDA fall while SCL is high. The flag is then set with status 0x08.
- R3: After an address byte, status is 0x18 (ACK) or 0x20 (NACK) when bit 0 was 0. It is 0x40 (ACK) or 0x48 (NACK) when bit 0 was 1.
- R4: A transmitted data byte gives status 0x28 if the slave pulled SDA low in the ninth bit, or 0x30 if it did not.
- R5: A received byte is placed in the data register. With acknowledge-enable high, the engine drives ACK and gives status 0x50. With it low, the engine leaves SDA high (NACK) and gives status 0x58.
- R6: The begin control is a level and is not cleared by the engine. If begin is still high when the flag is cleared while the bus is held, a repeated START follows (status 0x10) with no STOP in between.
- R7: Halt alone, at a flag clear, makes a STOP (SDA rises while SCL is high). The engine then returns to idle with both lines released, status 0xF8 and the flag low.
- R8: Halt and begin together, at a flag clear, make exactly one STOP and then one START. The flag is then set with status 0x08.
- R9: While the flag is set, SCL is held low and the flag stays set until cleared. While the flag is low, status reads 0xF8.
- R10: Bytes go on the wire MSB first. Inside a bit, SDA changes only while SCL is low.
- R11: During a byte, SCL stays high for 2·(clk_div+1) clock cycles per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_start | input | 1 | Begin request (level) |
| ctl_stop | input | 1 | Halt request (level, sampled at flag clear) |
| ctl_ack_en | input | 1 | Return ACK after received bytes when high |
| flag_clr | input | 1 | Clears the event flag and releases the engine |
| dat_wr | input | 1 | Write strobe for the data register |
| dat_wdata | input | BYTE_W | Value written to the data register |
| clk_div | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| sda_in | input | 1 | Sampled SDA line level |
| int_flag | output | 1 | Event flag |
| status | output | 8 | Status code of the last event, 0xF8 when none |
| dat_rdata | output | BYTE_W | Data register contents |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Some properties are checked by assertions on every clock: SCL held low during a flag, status 0xF8 whenever the flag is low, the flag staying set until cleared, the START code range, SDA steady while SCL is high inside a bit, and both lines released in idle. Other behaviour needs a live slave and so is shown only by the bench scenarios. This covers the mapping from ACK or NACK to each status code, the received bytes, MSB-first order (seen through the slave's memory contents), and the START and STOP counts for repeated and combined requests. The scenarios also measure the SCL high time at two divider settings.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    localparam logic [7:0] CODE_START   = 8'h08;
    localparam logic [7:0] CODE_RSTART  = 8'h10;
    localparam logic [7:0] CODE_AW_ACK  = 8'h18;
    localparam logic [7:0] CODE_AW_NACK = 8'h20;
    localparam logic [7:0] CODE_TX_ACK  = 8'h28;
    localparam logic [7:0] CODE_TX_NACK = 8'h30;
    localparam logic [7:0] CODE_AR_ACK  = 8'h40;
    localparam logic [7:0] CODE_AR_NACK = 8'h48;
    localparam logic [7:0] CODE_RX_ACK  = 8'h50;
    localparam logic [7:0] CODE_RX_NACK = 8'h58;
    localparam logic [7:0] CODE_IDLE    = 8'hF8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_BIT,
        S_ACK,
        S_STOP,
        S_HOLD
    } eng_state_t;

    typedef enum logic [1:0] {
        CX_ADDR,
        CX_TX,
        CX_RX
    } byte_ctx_t;

endpackage

// File: rtl/sbe_qtick.sv
module sbe_qtick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sbe_shreg.sv
module sbe_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else if (load) begin
            q <= ld_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end
endmodule

// File: rtl/sbe_master.sv
module sbe_master
    import sbe_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_ack_en,
    input  logic              flag_clr,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] dat_wdata,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              sda_in,
    output logic              int_flag,
    output logic [7:0]        status,
    output logic [BYTE_W-1:0] dat_rdata,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    eng_state_t        state;
    byte_ctx_t         ctx;
    logic [1:0]        qc;
    logic [CNT_W-1:0]  bitcnt;
    logic              owned;
    logic              restart;
    logic              pend_start;
    logic              rd_dir;
    logic              ack_seen;
    logic              ack_give;
    logic              samp;
    logic [BYTE_W-1:0] dat;
    logic              tick;
    logic [BYTE_W-1:0] sh_q;
    logic              sh_load;
    logic              sh_shift;
    logic [BYTE_W-1:0] sh_ld_val;
    logic [7:0]        ack_code;
    byte_ctx_t         ctx_after;
    logic              go_byte;
    logic              scl_low;
    logic              sda_low;

    sbe_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (clk_div),
        .tick (tick)
    );

    assign go_byte   = (state == S_HOLD) && flag_clr && !ctl_stop && !ctl_start;
    assign sh_load   = go_byte;
    assign sh_ld_val = (ctx == CX_RX) ? '1 : dat;
    assign sh_shift  = (state == S_BIT) && tick && (qc == 2'd3);

    sbe_shreg #(.W(BYTE_W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .ld_val(sh_ld_val),
        .shift (sh_shift),
        .sin   (samp),
        .q     (sh_q)
    );

    // status produced at the end of the ninth bit, and the context that follows
    always_comb begin
        ack_code  = CODE_IDLE;
        ctx_after = ctx;
        unique case (ctx)
            CX_ADDR: begin
                if (rd_dir) begin
                    ack_code  = ack_seen ? CODE_AR_ACK : CODE_AR_NACK;
                    ctx_after = CX_RX;
                end else begin
                    ack_code  = ack_seen ? CODE_AW_ACK : CODE_AW_NACK;
                    ctx_after = CX_TX;
                end
            end
            CX_TX:   ack_code = ack_seen ? CODE_TX_ACK : CODE_TX_NACK;
            CX_RX:   ack_code = ack_give ? CODE_RX_ACK : CODE_RX_NACK;
            default: ctx_after = CX_ADDR;
        endcase
    end

    // state register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            ctx        <= CX_ADDR;
            qc         <= 2'd0;
            bitcnt     <= '0;
            owned      <= 1'b0;
            restart    <= 1'b0;
            pend_start <= 1'b0;
            rd_dir     <= 1'b0;
            ack_seen   <= 1'b0;
            ack_give   <= 1'b0;
            samp       <= 1'b1;
            dat        <= '0;
            int_flag   <= 1'b0;
            status     <= CODE_IDLE;
        end else begin
            if (dat_wr) begin
                dat <= dat_wdata;
            end
            unique case (state)
                S_IDLE: begin
                    qc <= 2'd0;
                    if (ctl_start) begin
                        state   <= S_START;
                        restart <= 1'b0;
                    end
                end
                S_START: begin
                    if (tick) begin
                        qc <= qc + 2'd1;
                        if (qc == 2'd3) begin
                            state    <= S_HOLD;
                            owned    <= 1'b1;
                            ctx      <= CX_ADDR;
                            int_flag <= 1'b1;
                            status   <= restart ? CODE_RSTART : CODE_START;
                        end
                    end
                end
                S_BIT: begin
                    if (tick) begin
                        qc <= qc + 2'd1;
                        if (qc == 2'd2) begin
                            samp <= sda_in;
                        end
                        if (qc == 2'd3) begin
                            if (bitcnt == LAST_BIT) begin
                                state  <= S_ACK;
                                bitcnt <= '0;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                end
                S_ACK: begin
                    if (tick) begin
                        qc <= qc + 2'd1;
                        if (qc == 2'd2) begin
                            ack_seen <= !sda_in;
                        end
                        if (qc == 2'd3) begin
                            state    <= S_HOLD;
                            int_flag <= 1'b1;
                            status   <= ack_code;
                            ctx      <= ctx_after;
                            if (ctx == CX_RX) begin
                                dat <= sh_q;
                            end
                        end
                    end
                end
                S_STOP: begin
                    if (tick) begin
                        qc <= qc + 2'd1;
                        if (qc == 2'd3) begin
                            owned <= 1'b0;
                            if (pend_start) begin
                                state      <= S_START;
                                restart    <= 1'b0;
                                pend_start <= 1'b0;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                end
                S_HOLD: begin
                    qc <= 2'd0;
                    if (flag_clr) begin
                        int_flag <= 1'b0;
                        status   <= CODE_IDLE;
                        if (ctl_stop) begin
                            state      <= S_STOP;
                            pend_start <= ctl_start;
                        end else if (ctl_start) begin
                            state   <= S_START;
                            restart <= 1'b1;
                        end else begin
                            state    <= S_BIT;
                            bitcnt   <= '0;
                            ack_give <= ctl_ack_en;
                            if (ctx == CX_ADDR) begin
                                rd_dir <= dat[0];
                            end
                        end
                    end
                end
                default: begin
                    state    <= S_STOP;
                    qc       <= 2'd0;
                    int_flag <= 1'b0;
                    status   <= CODE_IDLE;
                end
            endcase
        end
    end

    // bus line drive per state and quarter
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (state)
            S_IDLE: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
            S_START: begin
                unique case (qc)
                    2'd0: scl_low = owned;
                    2'd1: scl_low = 1'b0;
                    2'd2: sda_low = 1'b1;
                    2'd3: begin
                        scl_low = 1'b1;
                        sda_low = 1'b1;
                    end
                    default: scl_low = 1'b0;
                endcase
            end
            S_BIT: begin
                scl_low = (qc == 2'd0) || (qc == 2'd3);
                sda_low = (ctx != CX_RX) && !sh_q[BYTE_W-1];
            end
            S_ACK: begin
                scl_low = (qc == 2'd0) || (qc == 2'd3);
                sda_low = (ctx == CX_RX) && ack_give;
            end
            S_STOP: begin
                scl_low = (qc == 2'd0);
                sda_low = (qc == 2'd0) || (qc == 2'd1);
            end
            S_HOLD: begin
                scl_low = 1'b1;
                sda_low = 1'b0;
            end
            default: begin
                scl_low = 1'b1;
                sda_low = 1'b1;
            end
        endcase
    end

    assign scl_oe    = scl_low;
    assign sda_oe    = sda_low;
    assign dat_rdata = dat;

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !int_flag |-> (status == CODE_IDLE)); // R9
    AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        int_flag |-> scl_oe); // R9
    AST_FLAG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && !flag_clr) |=> int_flag); // R9
    AST_START_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_START && state == S_HOLD) |-> (status == CODE_START || status == CODE_RSTART)); // R2
    AST_SDA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_BIT || state == S_ACK) && $past(state) == state && !scl_oe && !$past(scl_oe))
            |-> $stable(sda_oe)); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!scl_oe && !sda_oe)); // R7
endmodule

// File: tb/sim_sbe_master.sv
module sim_sbe_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIVW = 16;
    localparam int BW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ctl_start = 1'b0;
    logic            ctl_stop = 1'b0;
    logic            ctl_ack_en = 1'b0;
    logic            flag_clr = 1'b0;
    logic            dat_wr = 1'b0;
    logic [BW-1:0]   dat_wdata = '0;
    logic [DIVW-1:0] clk_div = 16'd3;
    logic            int_flag;
    logic [7:0]      status;
    logic [BW-1:0]   dat_rdata;
    logic            scl_oe;
    logic            sda_oe;
    logic            slv_low = 1'b0;

    wire scl_line = !scl_oe;
    wire sda_line = !(sda_oe || slv_low);

    sbe_master #(.DIV_W(DIVW), .BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ctl_ack_en(ctl_ack_en), .flag_clr(flag_clr), .dat_wr(dat_wr),
        .dat_wdata(dat_wdata), .clk_div(clk_div), .sda_in(sda_line),
        .int_flag(int_flag), .status(status), .dat_rdata(dat_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model: expected event codes and bus monitor
    logic [7:0] exp_code[$];
    string      exp_tag[$];
    logic p_scl = 1'b1, p_sda = 1'b1, p_flag = 1'b0;
    int hi_run = 0, last_hi = 0, n_start = 0, n_stop = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!int_flag) chk("R9 status idle while flag low", status, 8'hF8);
            else           chk("R9 SCL held while flag set", scl_line, 1'b0);
            if (int_flag && !p_flag) begin
                if (exp_code.size() == 0) chk("model unexpected event", status, 8'hF8);
                else chk(exp_tag.pop_front(), status, exp_code.pop_front());
            end
            if (p_scl && scl_line && p_sda && !sda_line) n_start++;
            if (p_scl && scl_line && !p_sda && sda_line) n_stop++;
            if (scl_line) hi_run++;
            else if (p_scl) begin last_hi = hi_run; hi_run = 0; end
        end
        p_scl = scl_line; p_sda = sda_line; p_flag = int_flag;
    end

    // ---------------- behavioural slave at address 0x50
    logic [7:0] mem [8];
    logic [7:0] sh = 8'h00, ptr = 8'h00, rdb = 8'h00;
    int   bitn = 0, phase = 0;
    logic active = 1'b0, mack = 1'b0, nack_data = 1'b0;
    logic s_pscl = 1'b1, s_psda = 1'b1;

    always @(negedge clk) begin
        if (s_pscl && scl_line && s_psda && !sda_line) begin
            active = 1'b1; bitn = 0; phase = 0; slv_low <= 1'b0;
        end else if (s_pscl && scl_line && !s_psda && sda_line) begin
            active = 1'b0; slv_low <= 1'b0;
        end else if (active && !s_pscl && scl_line) begin
            if (bitn < 8) begin sh = {sh[6:0], sda_line}; bitn++; end
            else if (bitn == 9) mack = !sda_line;
        end else if (active && s_pscl && !scl_line) begin
            if (bitn == 8) begin
                bitn = 9;
                case (phase)
                    0: if (sh[7:1] == 7'h50) begin phase = sh[0] ? 3 : 1; slv_low <= 1'b1; end
                       else begin active = 1'b0; slv_low <= 1'b0; end
                    1: begin ptr = sh; phase = 2; slv_low <= 1'b1; end
                    2: if (!nack_data) begin mem[ptr[2:0]] = sh; ptr++; slv_low <= 1'b1; end
                       else slv_low <= 1'b0;
                    default: slv_low <= 1'b0;
                endcase
            end else if (bitn == 9) begin
                bitn = 0; slv_low <= 1'b0;
                if (phase == 3 && mack) begin
                    rdb = mem[ptr[2:0]]; ptr++; slv_low <= !rdb[7];
                end else if (phase == 3) phase = 4;
            end else if (phase == 3 && bitn >= 1 && bitn <= 7) begin
                slv_low <= !rdb[7-bitn];
            end
        end
        s_pscl = scl_line; s_psda = sda_line;
    end

    // ---------------- stimulus helpers
    task automatic wait_flag();
        int n = 0;
        while (!int_flag && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) chk("watchdog event wait", 0, 1);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = d;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic step(input logic st, input logic sp, input logic ae,
                        input bit expect_evt, input logic [7:0] code, input string tag);
        @(negedge clk);
        ctl_start = st; ctl_stop = sp; ctl_ack_en = ae;
        if (expect_evt) begin exp_code.push_back(code); exp_tag.push_back(tag); end
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        if (expect_evt) wait_flag();
    endtask

    task automatic go_idle();
        ctl_stop = 1'b0; ctl_start = 1'b0;
        repeat (8 * (int'(clk_div) + 1) + 6) @(negedge clk);
        chk("R7 flag low after stop", int_flag, 1'b0);
        chk("R7 status idle after stop", status, 8'hF8);
        chk("R7 SCL released", scl_line, 1'b1);
        chk("R7 SDA released", sda_line, 1'b1);
    endtask

    task automatic begin_idle(input string tag);
        @(negedge clk);
        exp_code.push_back(8'h08); exp_tag.push_back(tag);
        ctl_start = 1'b1;
        wait_flag();
    endtask

    // ---------------- watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk("watchdog expired", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- scenarios
    initial begin
        int s0, p0;
        for (int i = 0; i < 8; i++) mem[i] = 8'h10 + 8'(i);
        repeat (4) @(negedge clk);
        chk("R1 status after reset", status, 8'hF8);
        chk("R1 flag after reset", int_flag, 1'b0);
        chk("R1 SCL released", scl_oe, 1'b0);
        chk("R1 SDA released", sda_oe, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // write: address, pointer, one data byte
        s0 = n_start; p0 = n_stop;
        begin_idle("R2 start from idle");
        ctl_start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R9 frozen bus keeps flag", int_flag, 1'b1);
        chk("R9 frozen bus SCL low", scl_line, 1'b0);
        wr(8'hA0); step(0, 0, 0, 1, 8'h18, "R3 write address ACK");
        wr(8'h03); step(0, 0, 0, 1, 8'h28, "R4 data ACK");
        wr(8'h5A); step(0, 0, 0, 1, 8'h28, "R4 data ACK");
        chk("R11 SCL high time div=3", last_hi, 8);
        step(0, 1, 0, 0, 8'h00, "");
        go_idle();
        chk("R10 MSB-first byte stored", mem[3], 8'h5A);
        chk("R2 one START on bus", n_start - s0, 1);
        chk("R7 one STOP on bus", n_stop - p0, 1);

        // read with held begin and repeated STARTs
        s0 = n_start; p0 = n_stop;
        begin_idle("R2 start from idle");
        step(1, 0, 0, 1, 8'h10, "R6 held begin gives repeated START");
        ctl_start = 1'b0;
        wr(8'hA0); step(0, 0, 0, 1, 8'h18, "R3 write address ACK");
        wr(8'h03); step(0, 0, 0, 1, 8'h28, "R4 pointer ACK");
        step(1, 0, 0, 1, 8'h10, "R6 repeated START");
        ctl_start = 1'b0;
        wr(8'hA1); step(0, 0, 0, 1, 8'h40, "R3 read address ACK");
        step(0, 0, 1, 1, 8'h50, "R5 receive with ACK");
        chk("R5 first received byte", dat_rdata, 8'h5A);
        step(0, 0, 0, 1, 8'h58, "R5 receive with NACK");
        chk("R5 second received byte", dat_rdata, 8'h14);
        step(0, 1, 0, 0, 8'h00, "");
        go_idle();
        chk("R6 START count with repeats", n_start - s0, 3);
        chk("R6 no STOP between repeats", n_stop - p0, 1);

        // error codes, combined halt+begin, slower divider
        clk_div = 16'd5;
        repeat (10) @(negedge clk);
        s0 = n_start; p0 = n_stop;
        begin_idle("R2 start from idle");
        ctl_start = 1'b0;
        wr(8'hA2); step(0, 0, 0, 1, 8'h20, "R3 write address NACK");
        step(1, 1, 0, 1, 8'h08, "R8 STOP then START");
        ctl_start = 1'b0;
        chk("R8 exactly one STOP", n_stop - p0, 1);
        chk("R8 START after STOP", n_start - s0, 2);
        wr(8'hA0); step(0, 0, 0, 1, 8'h18, "R3 write address ACK");
        wr(8'h07); step(0, 0, 0, 1, 8'h28, "R4 pointer ACK");
        nack_data = 1'b1;
        wr(8'h99); step(0, 0, 0, 1, 8'h30, "R4 data NACK");
        chk("R11 SCL high time div=5", last_hi, 12);
        nack_data = 1'b0;
        step(1, 0, 0, 1, 8'h10, "R6 repeated START");
        ctl_start = 1'b0;
        wr(8'hA3); step(0, 0, 0, 1, 8'h48, "R3 read address NACK");
        step(0, 1, 0, 0, 8'h00, "");
        go_idle();
        chk("R4 NACKed byte not stored", mem[7], 8'h17);
        chk("model all events seen", exp_code.size(), 0);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule